// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets synchronous logic reach an external asynchronous static RAM of 256K words by 16 bits. The host raises a request carrying an address, write data, a per-byte enable mask and a read/write flag. It holds that request until a one-cycle acknowledge comes back. For a read, the returned word is valid in the acknowledge cycle and stays valid until the next read completes.

On the memory side the controller drives every strobe straight from a flip-flop. These are an active-low chip select, an active-high chip select, one active-low byte control per lane, an active-low write enable and an active-low output enable. It also drives the data bus output with a separate drive-enable, and takes a separate data input.

Every phase length is a whole number of clock cycles. Each one is worked out from a clock-period parameter and a minimum in nanoseconds, always rounded up. The phases are the read access, the write pulse, the write recovery, the bus float time after a read, and the settle time after power-up.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, and in idle, the part is deselected: `mem_s1_n`=1, `mem_s2`=0, all `mem_bc_n` bits 1, `mem_w_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0 and `ack`=0.
- R2: After reset is released, the controller keeps the part deselected and accepts no request for PU = ceil(T_PU_NS/CLK_NS) cycles. A request already waiting is accepted on the clock edge after that.
- R3: A read with a nonzero mask holds the strobes for RD = ceil(85 ns/CLK_NS) cycles: both selects active, `mem_w_n`=1, `mem_oe_n`=0 and `mem_bc_n` = ~`bmask`. The data input is sampled at the edge that ends this window, and `ack` rises at that same edge.
- R4: Read data lane k (bits 8k+7:8k) comes from the memory when `bmask[k]`=1 and reads as zero when it is 0. Bit 0 of the mask and of `mem_bc_n` is the lower byte; bit 1 is the upper byte.
- R5: A write holds `mem_w_n` low for WP = max(ceil(60/CLK_NS), ceil(45/CLK_NS)) cycles. After that comes a recovery of REC = max(ceil(85/CLK_NS)−WP, 1) cycles. Address, selects, byte controls and driven write data stay fixed through both.
- R6: A write changes only the memory lanes whose mask bit is 1.
- R7: A request with an all-zero mask is acknowledged on the first edge that sees it in idle, and no select or strobe goes active.
- R8: The data bus is never driven while `mem_output enable` (`mem_oe_n`) is low. After a read, no write may drive the bus until at least HZ = ceil(30/CLK_NS) cycles after `mem_oe_n` rose.
- R9: `ack` is high for exactly one cycle per request. The memory address does not change while a select stays active.
- R10: `mem_w_n` and `mem_oe_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (18) | Word address |
| wdata | input | DW (16) | Write data |
| bmask | input | DW/8 (2) | Byte enables, bit 0 = lower byte |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | DW (16) | Read data, disabled lanes zero |
| mem_a | output | AW (18) | Memory address |
| mem_s1_n | output | 1 | Chip select, active low |
| mem_s2 | output | 1 | Chip select, active high |
| mem_bc_n | output | DW/8 (2) | Byte controls, active low, bit 0 = lower byte |
| mem_w_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_o | output | DW (16) | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | DW (16) | Data bus value from memory |

## Verification
The strobes follow from a single state and one down-counter. A wrong state or a miscounted phase therefore shows on the memory pins in the very cycle it happens, as a strobe that is early, late or missing. The bench's per-cycle model catches that within one clock. A bad float counter shows up only on a write that directly follows a read, as a bus drive that starts too soon. The bench forces exactly that case and checks its latency. Lane-mask faults are silent until the word is read back, so every masked write is followed by full-width and single-lane reads.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WREC,
    ST_DONE
  } ctrl_st_t;

  // minimum time in ns -> whole clock cycles, rounded up
  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW      = 8,
  parameter int RST_LEN = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] len,
  output logic          expired
);

  logic [CW-1:0] cnt;

  // a phase of length L keeps expired low for L-1 cycles after loading
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CW'(RST_LEN - 1);
    end else if (load) begin
      cnt <= len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/sram_turn_guard.sv
`timescale 1ns/1ps
module sram_turn_guard #(
  parameter int HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic clear
);

  localparam int GW = $clog2(HOLD + 1);

  logic [GW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= GW'(HOLD);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign clear = (left == '0);

endmodule

// File: rtl/sram_lane_gate.sv
`timescale 1ns/1ps
module sram_lane_gate #(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]   en,
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dout[8*g +: 8] = en[g] ? din[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 85,
  parameter int T_WP_NS  = 60,
  parameter int T_DS_NS  = 45,
  parameter int T_WC_NS  = 85,
  parameter int T_HZ_NS  = 30,
  parameter int T_PU_NS  = 5000000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            we,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [DW/8-1:0] bmask,
  output logic            ack,
  output logic [DW-1:0]   rdata,
  output logic [AW-1:0]   mem_a,
  output logic            mem_s1_n,
  output logic            mem_s2,
  output logic [DW/8-1:0] mem_bc_n,
  output logic            mem_w_n,
  output logic            mem_oe_n,
  output logic [DW-1:0]   mem_dq_o,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_i
);

  localparam int LANES   = DW / 8;
  localparam int RD_CYC  = imax(ns2cyc(T_RC_NS, CLK_NS), 1);
  localparam int WP_CYC  = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_DS_NS, CLK_NS)), 1);
  localparam int WC_CYC  = ns2cyc(T_WC_NS, CLK_NS);
  localparam int REC_CYC = imax(WC_CYC - WP_CYC, 1);
  localparam int HZ_CYC  = imax(ns2cyc(T_HZ_NS, CLK_NS), 1);
  localparam int PU_CYC  = imax(ns2cyc(T_PU_NS, CLK_NS), 1);
  localparam int MAXLEN  = imax(imax(PU_CYC, RD_CYC), imax(WP_CYC, REC_CYC));
  localparam int TCW     = $clog2(MAXLEN + 1);

  ctrl_st_t       st;
  logic           tmr_load;
  logic [TCW-1:0] tmr_len;
  logic           tmr_done;
  logic           turn_clear;
  logic           any_lane;
  logic           accept_rd;
  logic           accept_wr;
  logic [DW-1:0]  rd_gated;

  assign any_lane  = |bmask;
  assign accept_rd = (st == ST_IDLE) && req && any_lane && !we;
  assign accept_wr = (st == ST_IDLE) && req && any_lane && we && turn_clear;
  assign tmr_load  = accept_rd || accept_wr || ((st == ST_WPULSE) && tmr_done);

  always_comb begin
    if (accept_rd)      tmr_len = TCW'(RD_CYC);
    else if (accept_wr) tmr_len = TCW'(WP_CYC);
    else                tmr_len = TCW'(REC_CYC);
  end

  sram_phase_timer #(.CW(TCW), .RST_LEN(PU_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .len     (tmr_len),
    .expired (tmr_done)
  );

  sram_turn_guard #(.HOLD(HZ_CYC)) u_turn (
    .clk   (clk),
    .rst   (rst),
    .start ((st == ST_READ) && tmr_done),
    .clear (turn_clear)
  );

  sram_lane_gate #(.LANES(LANES)) u_gate (
    .en   (~mem_bc_n),
    .din  (mem_dq_i),
    .dout (rd_gated)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_PWRUP;
      ack       <= 1'b0;
      rdata     <= '0;
      mem_a     <= '0;
      mem_s1_n  <= 1'b1;
      mem_s2    <= 1'b0;
      mem_bc_n  <= '1;
      mem_w_n   <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_o  <= '0;
      mem_dq_oe <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (st)
        ST_PWRUP: begin
          if (tmr_done) st <= ST_IDLE;
        end
        ST_IDLE: begin
          if (req && !any_lane) begin
            ack <= 1'b1;
            st  <= ST_DONE;
          end else if (accept_rd) begin
            mem_a    <= addr;
            mem_s1_n <= 1'b0;
            mem_s2   <= 1'b1;
            mem_bc_n <= ~bmask;
            mem_oe_n <= 1'b0;
            st       <= ST_READ;
          end else if (accept_wr) begin
            mem_a     <= addr;
            mem_s1_n  <= 1'b0;
            mem_s2    <= 1'b1;
            mem_bc_n  <= ~bmask;
            mem_w_n   <= 1'b0;
            mem_dq_o  <= wdata;
            mem_dq_oe <= 1'b1;
            st        <= ST_WPULSE;
          end
        end
        ST_READ: begin
          if (tmr_done) begin
            rdata    <= rd_gated;
            mem_s1_n <= 1'b1;
            mem_s2   <= 1'b0;
            mem_bc_n <= '1;
            mem_oe_n <= 1'b1;
            ack      <= 1'b1;
            st       <= ST_DONE;
          end
        end
        ST_WPULSE: begin
          if (tmr_done) begin
            mem_w_n <= 1'b1;
            st      <= ST_WREC;
          end
        end
        ST_WREC: begin
          if (tmr_done) begin
            mem_s1_n  <= 1'b1;
            mem_s2    <= 1'b0;
            mem_bc_n  <= '1;
            mem_dq_oe <= 1'b0;
            ack       <= 1'b1;
            st        <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int AW      = 18,
  parameter int DW      = 16,
  parameter int CLK_NS  = 10,
  parameter int T_HZ_NS = 30
) (
  input logic            clk,
  input logic            rst,
  input logic            ack,
  input logic [AW-1:0]   mem_a,
  input logic            mem_s1_n,
  input logic            mem_s2,
  input logic [DW/8-1:0] mem_bc_n,
  input logic            mem_w_n,
  input logic            mem_oe_n,
  input logic            mem_dq_oe
);

  localparam int HZ_CYC = imax(ns2cyc(T_HZ_NS, CLK_NS), 1);
  localparam int SAT    = HZ_CYC + 1;
  localparam int SW     = $clog2(SAT + 1);

  logic [SW-1:0] since_oe;

  always_ff @(posedge clk) begin
    if (rst)                   since_oe <= SW'(SAT);
    else if (!mem_oe_n)        since_oe <= '0;
    else if (since_oe != SW'(SAT)) since_oe <= since_oe + 1'b1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (mem_s1_n && !mem_s2 && (&mem_bc_n) && mem_w_n && mem_oe_n && !mem_dq_oe && !ack));

  // R3
  read_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_s1_n && mem_s2 && mem_w_n && !(&mem_bc_n)));

  // R5
  write_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_w_n |-> (mem_dq_oe && !mem_s1_n && mem_s2 && !(&mem_bc_n)));

  // R8
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  // R8
  turnaround_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (since_oe >= SW'(HZ_CYC)));

  // R9
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_s1_n && $past(!mem_s1_n)) |-> $stable(mem_a));

  // R10
  no_w_oe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(!mem_w_n && !mem_oe_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_HZ_NS(T_HZ_NS)
) u_chk (.*);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;

  localparam int CLK_NS = 5;
  localparam int PU_NS  = 200;
  localparam int RD_C   = (85 + CLK_NS - 1) / CLK_NS;
  localparam int WPA    = (60 + CLK_NS - 1) / CLK_NS;
  localparam int WPB    = (45 + CLK_NS - 1) / CLK_NS;
  localparam int WP_C   = (WPA > WPB) ? WPA : WPB;
  localparam int WC_C   = (85 + CLK_NS - 1) / CLK_NS;
  localparam int REC_C  = (WC_C - WP_C > 1) ? WC_C - WP_C : 1;
  localparam int HZ_C   = (30 + CLK_NS - 1) / CLK_NS;
  localparam int PU_C   = (PU_NS + CLK_NS - 1) / CLK_NS;

  localparam int PH_PU = 0, PH_ID = 1, PH_RD = 2, PH_WP = 3, PH_WR = 4, PH_DN = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  bmask = '0;
  logic        ack;
  logic [15:0] rdata;
  logic [17:0] mem_a;
  logic        mem_s1_n, mem_s2, mem_w_n, mem_oe_n, mem_dq_oe;
  logic [1:0]  mem_bc_n;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  always #2.5 clk = ~clk;

  sram_lane_ctrl #(.CLK_NS(CLK_NS), .T_PU_NS(PU_NS)) u_sram_lane_ctrl (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .bmask(bmask), .ack(ack), .rdata(rdata), .mem_a(mem_a),
    .mem_s1_n(mem_s1_n), .mem_s2(mem_s2), .mem_bc_n(mem_bc_n),
    .mem_w_n(mem_w_n), .mem_oe_n(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- memory model (asynchronous part) ----------------
  logic [15:0] arr [0:1023];

  always_comb begin
    mem_dq_i = 16'hA5A5;
    if (!mem_s1_n && mem_s2 && mem_w_n && !mem_oe_n)
      for (int l = 0; l < 2; l++)
        if (!mem_bc_n[l]) mem_dq_i[8*l +: 8] = arr[mem_a[9:0]][8*l +: 8];
  end

  int since_oe = 1000;
  bit live = 0;

  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 1024; i++) arr[i] = 16'h0000;
    end else if (!mem_s1_n && mem_s2 && !mem_w_n) begin
      chk(mem_dq_oe, "R5", "bus undriven during write overlap", mem_dq_oe, 1);
      for (int l = 0; l < 2; l++)
        if (!mem_bc_n[l]) arr[mem_a[9:0]][8*l +: 8] = mem_dq_o[8*l +: 8];
    end
    if (live && !rst) begin
      chk(!(!mem_w_n && !mem_oe_n), "R10", "W and OE low together", {mem_w_n, mem_oe_n}, 2'b11);
      chk(!(mem_dq_oe && !mem_oe_n), "R8", "bus driven with OE low", mem_dq_oe, 0);
    end
    if (!mem_oe_n) since_oe = 0;
    else if (since_oe < 1000) since_oe++;
  end

  logic prev_dq_oe = 1'b0;
  always @(negedge clk) begin
    if (live && !rst && mem_dq_oe && !prev_dq_oe)
      chk(since_oe >= HZ_C, "R8", "drive too soon after OE rose", since_oe, HZ_C);
    prev_dq_oe = mem_dq_oe;
  end

  // ---------------- cycle reference model ----------------
  int          m_ph, m_left, m_guard;
  logic [17:0] m_a;
  logic [1:0]  m_mask;
  logic [15:0] m_wd, e_rd;
  logic        e_ack;

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= PH_PU; m_left <= PU_C; m_guard <= 0;
      e_ack <= 1'b0; e_rd <= 16'h0; m_a <= '0; m_mask <= '0; m_wd <= '0;
      live <= 1'b1;
    end else begin
      e_ack <= 1'b0;
      if (m_guard > 0) m_guard <= m_guard - 1;
      case (m_ph)
        PH_PU: if (m_left == 1) m_ph <= PH_ID; else m_left <= m_left - 1;
        PH_ID: if (req) begin
          if (bmask == 2'b00) begin
            e_ack <= 1'b1; m_ph <= PH_DN;
          end else if (!we) begin
            m_ph <= PH_RD; m_left <= RD_C; m_a <= addr; m_mask <= bmask;
          end else if (m_guard == 0) begin
            m_ph <= PH_WP; m_left <= WP_C; m_a <= addr; m_mask <= bmask; m_wd <= wdata;
          end
        end
        PH_RD: if (m_left == 1) begin
          logic [15:0] v;
          v = arr[m_a[9:0]];
          e_rd <= {m_mask[1] ? v[15:8] : 8'h00, m_mask[0] ? v[7:0] : 8'h00};
          e_ack <= 1'b1; m_ph <= PH_DN; m_guard <= HZ_C;
        end else m_left <= m_left - 1;
        PH_WP: if (m_left == 1) begin m_ph <= PH_WR; m_left <= REC_C; end
               else m_left <= m_left - 1;
        PH_WR: if (m_left == 1) begin e_ack <= 1'b1; m_ph <= PH_DN; end
               else m_left <= m_left - 1;
        default: m_ph <= PH_ID;
      endcase
    end
  end

  function automatic string ph_tag(input int ph);
    case (ph)
      PH_PU:   return "R2";
      PH_ID:   return "R1";
      PH_RD:   return "R3";
      PH_WP:   return "R5";
      PH_WR:   return "R5";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (live) begin
      bit sel;
      string tg;
      sel = (m_ph == PH_RD) || (m_ph == PH_WP) || (m_ph == PH_WR);
      tg  = rst ? "R1" : ph_tag(m_ph);
      chk(mem_s1_n == !sel, tg, "mem_s1_n", mem_s1_n, !sel);
      chk(mem_s2 == sel, tg, "mem_s2", mem_s2, sel);
      chk(mem_bc_n == (sel ? ~m_mask : 2'b11), tg, "mem_bc_n", mem_bc_n, sel ? ~m_mask : 2'b11);
      chk(mem_w_n == (m_ph != PH_WP), tg, "mem_w_n", mem_w_n, m_ph != PH_WP);
      chk(mem_oe_n == (m_ph != PH_RD), tg, "mem_oe_n", mem_oe_n, m_ph != PH_RD);
      chk(mem_dq_oe == (m_ph == PH_WP || m_ph == PH_WR), tg, "mem_dq_oe", mem_dq_oe,
          m_ph == PH_WP || m_ph == PH_WR);
      if (sel) chk(mem_a == m_a, "R9", "mem_a held", mem_a, m_a);
      if (mem_dq_oe) chk(mem_dq_o == m_wd, "R5", "mem_dq_o", mem_dq_o, m_wd);
      chk(ack == e_ack, "R9", "ack", ack, e_ack);
      chk(rdata == e_rd, "R4", "rdata", rdata, e_rd);
    end
  end

  // ---------------- stimulus ----------------
  logic [15:0] shadow [0:1023];

  task automatic do_op(input int gap, input bit w, input logic [17:0] a,
                       input logic [15:0] d, input logic [1:0] m,
                       input int exp_n, input string tg);
    int  n = 0;
    bit  strobe = 0;
    logic [15:0] s, e;
    repeat (gap) @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; bmask = m;
    do begin
      @(negedge clk);
      n++;
      if (!mem_s1_n || !mem_w_n || !mem_oe_n) strobe = 1;
    end while (!ack && n < 3000);
    req = 1'b0;
    if (n >= 3000) chk(0, tg, "watchdog: no ack", n, 0);
    if (exp_n >= 0) chk(n == exp_n, tg, "latency", n, exp_n);
    if (m == 2'b00) chk(!strobe, "R7", "strobe on empty mask", strobe, 0);
    s = shadow[a[9:0]];
    if (w) begin
      if (m[0]) s[7:0]  = d[7:0];
      if (m[1]) s[15:8] = d[15:8];
      shadow[a[9:0]] = s;
    end else if (m != 2'b00) begin
      e = {m[1] ? s[15:8] : 8'h00, m[0] ? s[7:0] : 8'h00};
      chk(rdata == e, tg, "read data", rdata, e);
    end
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) shadow[i] = 16'h0000;
    repeat (4) @(negedge clk);
    // R1: deselected under reset
    chk(mem_s1_n && !mem_s2 && (&mem_bc_n) && mem_w_n && mem_oe_n && !mem_dq_oe && !ack,
        "R1", "reset state", {mem_s1_n, mem_s2, mem_w_n, mem_oe_n, mem_dq_oe, ack}, 6'b101100);
    rst = 1'b0;
    // R2: request waiting from release is held off for the power-up window
    do_op(0, 0, 18'h00000, 16'h0, 2'b11, PU_C + 1 + RD_C, "R2");
    // R5: plain write after idle gap
    do_op(10, 1, 18'h00000, 16'h1234, 2'b11, WP_C + REC_C + 1, "R5");
    // R3: read after idle gap
    do_op(2, 0, 18'h00000, 16'h0, 2'b11, RD_C + 1, "R3");
    // R8: write immediately after a read waits for bus float; R6 lower lane only
    do_op(0, 1, 18'h00000, 16'hABCD, 2'b01, HZ_C + 1 + WP_C + REC_C, "R8");
    do_op(2, 0, 18'h00000, 16'h0, 2'b11, RD_C + 1, "R6");
    // R4: single-lane reads zero the other lane
    do_op(2, 0, 18'h00000, 16'h0, 2'b10, RD_C + 1, "R4");
    do_op(2, 0, 18'h00000, 16'h0, 2'b01, RD_C + 1, "R4");
    // R6: upper lane only at top address
    do_op(10, 1, 18'h3FFFF, 16'hBEEF, 2'b10, WP_C + REC_C + 1, "R6");
    do_op(2, 0, 18'h3FFFF, 16'h0, 2'b11, RD_C + 1, "R6");
    // R7: empty-mask write and read, then confirm memory untouched
    do_op(3, 1, 18'h3FFFF, 16'hFFFF, 2'b00, 1, "R7");
    do_op(3, 0, 18'h3FFFF, 16'h0, 2'b00, 1, "R7");
    do_op(2, 0, 18'h3FFFF, 16'h0, 2'b11, RD_C + 1, "R7");
    // mixed patterns
    for (int k = 0; k < 8; k++)
      do_op(1, 1, 18'(k * 37 + 100), 16'(k * 16'h1111) ^ 16'h0F0F, 2'(k % 3 + 1), -1, "R6");
    for (int k = 0; k < 8; k++)
      do_op(k % 3, 0, 18'(k * 37 + 100), 16'h0, 2'b11, -1, "R4");
    repeat (5) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule